// File: doc/BRIEF.md
# Multi-Line Write Staging Cache

This block sits between the serial bus slave of a small nonvolatile memory and its storage array. It collects the data bytes of one write transfer in a 64-byte staging buffer, organised as eight lines of eight bytes. The slave first hands it a 12-bit start address. It then passes each received data byte as a one-cycle strobe. The cache stores every byte at a write index that advances through the buffer. The upper address bits never change during a transfer, so all captured bytes belong to one 64-byte region of the array.

When the slave reports a STOP, the cache commits what it captured through a simple synchronous write port. It walks the loaded lines in ascending line order. Each loaded line takes a fixed slot of `LINE_CYC` clock cycles, and the bytes of the line go out during the first eight cycles of its slot. Only bytes that were actually received are written, so neighbouring array bytes keep their old contents. `busy` stays high for the whole commit, and the slave uses it to withhold acknowledges. The commit time therefore grows with the number of lines touched.

Top module: `line_write_cache`

## Requirements
- R1: After reset `busy` and `mem_we` are low, and no byte is held in the buffer.
- R2: A byte accepted while the 6-bit write index is i is written to array address {start_addr[11:6], i}, with the byte value received.
- R3: After each accepted byte only the 6 low index bits increment. Offset bits [2:0] wrap from 7 to 0 and carry into line bits [5:3], and address bits [11:6] stay fixed for the transfer.
- R4: When more than 64 bytes arrive before STOP, the index wraps from 63 to 0 and later bytes overwrite earlier ones. Only the last value at each position is written.
- R5: A STOP with no byte captured starts no commit: `busy` stays low and `mem_we` stays low.
- R6: A STOP with bytes captured raises `busy` on the next clock edge. `busy` then stays high for exactly N*LINE_CYC cycles, where N is the number of lines holding at least one received byte.
- R7: A commit performs exactly one array write per distinct received position, in ascending line order and ascending offset order within each line. It writes nothing for positions never received.
- R8: While `busy` is high, `ld_valid`, `byte_valid` and `stop` are ignored: nothing they carry is captured or written.
- R9: When a commit ends, all received marks clear. The next transfer writes only its own bytes.
- R10: `mem_we` is only ever high while `busy` is high.
- R11: If `ld_valid` and `byte_valid` are high in the same idle cycle, the address load wins and the byte is dropped. A `stop` in an idle cycle overrides both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load a new start address |
| ld_addr | input | 12 | Start address of the transfer |
| byte_valid | input | 1 | One received data byte is present |
| byte_data | input | 8 | Received data byte |
| stop | input | 1 | STOP seen on the bus; begin commit |
| busy | output | 1 | Commit in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 12 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The main function is driven with transfers of different shapes, and each shape separates a different fault:
- a single aligned full line;
- a short burst that starts mid-line and crosses into the next line, which shows whether the offset carries into the line bits;
- a burst that starts near the end of the buffer, which shows whether the index wraps without touching the upper address bits;
- a complete 64-byte fill, which exercises the longest busy time;
- a 70-byte overrun, which shows whether the last value wins;
- a single byte at the top address.

For every commit, the busy length, the write count and each written address and value are compared with a model of the buffer. Directed cases cover a STOP with nothing captured, inputs poked during a commit, and a second transfer after a commit, which separate a stale received mask from a correct clear.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
   typedef enum logic {
      CS_IDLE   = 1'b0,
      CS_COMMIT = 1'b1
   } commit_state_t;
endpackage

// File: rtl/lwc_pointer.sv
module lwc_pointer #(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_en,
   input  logic [ADDR_W-1:0]       load_addr,
   input  logic                    step_en,
   output logic [ADDR_W-IDX_W-1:0] page_hi,
   output logic [IDX_W-1:0]        idx
);
   localparam int HI_W = ADDR_W - IDX_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_hi <= '0;
         idx     <= '0;
      end else if (load_en) begin
         page_hi <= load_addr[ADDR_W-1:IDX_W];
         idx     <= load_addr[IDX_W-1:0];
      end else if (step_en) begin
         idx <= idx + IDX_W'(1);
      end
   end

   if (HI_W < 1) begin : g_bad_split
      $error("lwc_pointer: ADDR_W must exceed IDX_W");
   end
endmodule

// File: rtl/lwc_store.sv
module lwc_store #(
   parameter int DATA_W     = 8,
   parameter int LINE_BYTES = 8,
   parameter int NUM_LINES  = 8
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    wr_en,
   input  logic [$clog2(LINE_BYTES*NUM_LINES)-1:0] wr_idx,
   input  logic [DATA_W-1:0]                       wr_data,
   input  logic                                    clr,
   input  logic [$clog2(LINE_BYTES*NUM_LINES)-1:0] rd_idx,
   output logic [DATA_W-1:0]                       rd_data,
   output logic                                    rd_valid,
   output logic [NUM_LINES-1:0]                    line_mask,
   output logic                                    any_valid
);
   localparam int BUF_BYTES = LINE_BYTES * NUM_LINES;
   localparam int IDX_W     = $clog2(BUF_BYTES);
   localparam int OFS_W     = $clog2(LINE_BYTES);
   localparam int LINE_W    = IDX_W - OFS_W;

   logic [DATA_W-1:0]    mem [BUF_BYTES];
   logic [BUF_BYTES-1:0] vflat;
   logic [LINE_W-1:0]    wr_line;
   logic [OFS_W-1:0]     wr_ofs;

   assign wr_line = wr_idx[IDX_W-1:OFS_W];
   assign wr_ofs  = wr_idx[OFS_W-1:0];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [LINE_BYTES-1:0] vmark;
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            vmark <= '0;
         end else if (wr_en && wr_line == LINE_W'(l)) begin
            vmark[wr_ofs] <= 1'b1;
         end
      end
      assign vflat[l*LINE_BYTES +: LINE_BYTES] = vmark;
      assign line_mask[l] = |vmark;
   end

   assign rd_data   = mem[rd_idx];
   assign rd_valid  = vflat[rd_idx];
   assign any_valid = |line_mask;
endmodule

// File: rtl/lwc_sequencer.sv
module lwc_sequencer
   import lwc_pkg::*;
#(
   parameter int LINE_BYTES = 8,
   parameter int NUM_LINES  = 8,
   parameter int LINE_CYC   = 625000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [NUM_LINES-1:0]          line_mask,
   output logic                          busy,
   output logic [$clog2(NUM_LINES)-1:0]  line_sel,
   output logic [$clog2(LINE_BYTES)-1:0] ofs,
   output logic                          wr_phase,
   output logic                          done
);
   localparam int LINE_W = $clog2(NUM_LINES);
   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int TMR_W  = $clog2(LINE_CYC);
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(LINE_CYC - 1);
   localparam logic [TMR_W-1:0] TMR_WEND = TMR_W'(LINE_BYTES);

   commit_state_t        state;
   logic [NUM_LINES-1:0] pend;
   logic [NUM_LINES-1:0] src;
   logic [LINE_W-1:0]    next_line;
   logic [TMR_W-1:0]     tmr;
   logic                 slot_end;

   // remaining lines once the current slot finishes, or the loaded set when idle
   always_comb begin
      if (state == CS_COMMIT) begin
         src = pend;
         src[line_sel] = 1'b0;
      end else begin
         src = line_mask;
      end
   end

   // lowest remaining line is served first
   always_comb begin
      next_line = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (src[i]) next_line = LINE_W'(i);
      end
   end

   assign slot_end = (state == CS_COMMIT) && (tmr == TMR_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= CS_IDLE;
         pend     <= '0;
         line_sel <= '0;
         tmr      <= '0;
      end else if (state == CS_IDLE) begin
         if (start) begin
            state    <= CS_COMMIT;
            pend     <= line_mask;
            line_sel <= next_line;
            tmr      <= '0;
         end
      end else if (slot_end) begin
         tmr <= '0;
         if (|src) begin
            pend     <= src;
            line_sel <= next_line;
         end else begin
            pend  <= '0;
            state <= CS_IDLE;
         end
      end else begin
         tmr <= tmr + TMR_W'(1);
      end
   end

   assign busy     = (state == CS_COMMIT);
   assign wr_phase = busy && (tmr < TMR_WEND);
   assign ofs      = tmr[OFS_W-1:0];
   assign done     = slot_end && !(|src);

   if (LINE_CYC < LINE_BYTES) begin : g_bad_slot
      $error("lwc_sequencer: LINE_CYC must cover one cycle per line byte");
   end
endmodule

// File: rtl/line_write_cache.sv
module line_write_cache #(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 8,
   parameter int LINE_BYTES = 8,
   parameter int NUM_LINES  = 8,
   parameter int LINE_CYC   = 625000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   localparam int BUF_BYTES = LINE_BYTES * NUM_LINES;
   localparam int IDX_W     = $clog2(BUF_BYTES);
   localparam int OFS_W     = $clog2(LINE_BYTES);
   localparam int LINE_W    = $clog2(NUM_LINES);
   localparam int HI_W      = ADDR_W - IDX_W;

   logic [HI_W-1:0]      page_hi;
   logic [IDX_W-1:0]     idx;
   logic                 accept;
   logic                 load_en;
   logic                 step_en;
   logic                 start;
   logic                 any_valid;
   logic [NUM_LINES-1:0] line_mask;
   logic [LINE_W-1:0]    line_sel;
   logic [OFS_W-1:0]     ofs;
   logic                 wr_phase;
   logic                 done;
   logic                 rd_valid;

   // idle cycles only; stop overrides, address load beats a byte
   assign accept  = !busy && !stop;
   assign load_en = accept && ld_valid;
   assign step_en = accept && !ld_valid && byte_valid;
   assign start   = stop && !busy && any_valid;

   lwc_pointer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_addr(ld_addr), .step_en(step_en),
      .page_hi(page_hi), .idx(idx)
   );

   lwc_store #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(step_en), .wr_idx(idx), .wr_data(byte_data), .clr(done),
      .rd_idx({line_sel, ofs}), .rd_data(mem_wdata), .rd_valid(rd_valid),
      .line_mask(line_mask), .any_valid(any_valid)
   );

   lwc_sequencer #(.LINE_BYTES(LINE_BYTES), .NUM_LINES(NUM_LINES), .LINE_CYC(LINE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .start(start), .line_mask(line_mask),
      .busy(busy), .line_sel(line_sel), .ofs(ofs), .wr_phase(wr_phase), .done(done)
   );

   assign mem_we   = wr_phase && rd_valid;
   assign mem_addr = {page_hi, line_sel, ofs};

   if ((1 << OFS_W) != LINE_BYTES || (1 << LINE_W) != NUM_LINES) begin : g_bad_geom
      $error("line_write_cache: LINE_BYTES and NUM_LINES must be powers of two");
   end
   if (HI_W < 1) begin : g_bad_addr
      $error("line_write_cache: address too narrow for the buffer");
   end
endmodule

// File: rtl/line_write_cache_chk.sv
module line_write_cache_chk #(
   parameter int IDX_W = 6,
   parameter int HI_W  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_valid,
   input logic             byte_valid,
   input logic             stop,
   input logic             busy,
   input logic             mem_we,
   input logic             any_valid,
   input logic [HI_W-1:0]  page_hi,
   input logic [IDX_W-1:0] idx
);
   a_r10_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   a_r5_empty_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !busy && !any_valid) |=> !busy);

   a_r6_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop));

   a_r8_hold_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(idx) && $stable(page_hi)));

   a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !ld_valid && !stop && !busy) |=>
         (idx == IDX_W'($past(idx) + 1'b1)) && $stable(page_hi));

   a_r9_marks_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !any_valid);
endmodule

bind line_write_cache line_write_cache_chk #(.IDX_W(IDX_W), .HI_W(HI_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .byte_valid(byte_valid),
   .stop(stop), .busy(busy), .mem_we(mem_we), .any_valid(any_valid),
   .page_hi(page_hi), .idx(idx)
);

// File: tb/line_write_cache_tb.sv
module line_write_cache_tb;
   localparam int LC = 12;
   localparam int NV = 6;
   // {start address[27:16], byte count[15:8], first data value[7:0]}
   localparam logic [27:0] VEC [NV] = '{
      {12'h000, 8'd8,  8'h10},   // one aligned line
      {12'h125, 8'd6,  8'h20},   // crosses line 4 -> 5
      {12'hABE, 8'd4,  8'h30},   // index 63 -> 0, upper bits fixed
      {12'h7C0, 8'd64, 8'h40},   // full buffer
      {12'h210, 8'd70, 8'h80},   // overrun, overwrite
      {12'hFFF, 8'd1,  8'hF0}    // single top byte
   };
   localparam string VTAG [NV] = '{"R2", "R3", "R3", "R6", "R4", "R2"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_valid = 1'b0;
   logic [11:0] ld_addr = '0;
   logic byte_valid = 1'b0;
   logic [7:0] byte_data = '0;
   logic stop = 1'b0;
   logic busy, mem_we;
   logic [11:0] mem_addr;
   logic [7:0] mem_wdata;

   always #4 clk = ~clk;

   line_write_cache #(.LINE_CYC(LC)) u_dut (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .byte_valid(byte_valid), .byte_data(byte_data), .stop(stop),
      .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   int checks = 0;
   int fails = 0;
   int busy_cnt = 0;
   int wr_n = 0;
   int stray = 0;
   logic [11:0] wr_a [128];
   logic [7:0]  wr_d [128];
   logic [7:0]  m_dat [64];
   bit          m_val [64];
   logic [5:0]  m_hi = '0;
   logic [5:0]  m_ptr = '0;
   bit          finished = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_cnt++;
         if (mem_we) begin
            if (wr_n < 128) begin
               wr_a[wr_n] = mem_addr;
               wr_d[wr_n] = mem_wdata;
            end
            wr_n++;
            if (!busy) stray++;
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic load(logic [11:0] a);
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = a;
      m_hi = a[11:6]; m_ptr = a[5:0];
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic send(int n, logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         byte_valid = 1'b1; byte_data = seed + 8'(i);
         m_dat[m_ptr] = seed + 8'(i); m_val[m_ptr] = 1'b1; m_ptr = m_ptr + 6'd1;
         @(negedge clk);
      end
      byte_valid = 1'b0;
   endtask

   task automatic commit(bit poke);
      int k;
      busy_cnt = 0; wr_n = 0;
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      k = 0;
      while (busy && k < 2000) begin
         if (poke && k < 5) begin
            ld_valid = 1'b1; ld_addr = 12'h000;
            byte_valid = 1'b1; byte_data = 8'hEE; stop = 1'b1;
         end else begin
            ld_valid = 1'b0; byte_valid = 1'b0; stop = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      ld_valid = 1'b0; byte_valid = 1'b0; stop = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_commit(string tag);
      int nl = 0, ne = 0, bad = 0;
      for (int l = 0; l < 8; l++) begin
         bit hit = 1'b0;
         for (int o = 0; o < 8; o++) begin
            if (m_val[l*8+o]) begin
               hit = 1'b1;
               if (ne < wr_n && ne < 128) begin
                  if (wr_a[ne] != {m_hi, 3'(l), 3'(o)} || wr_d[ne] != m_dat[l*8+o]) bad++;
               end
               ne++;
            end
         end
         if (hit) nl++;
      end
      chk("R6", {tag, " busy cycles"}, busy_cnt, nl * LC);
      chk("R7", {tag, " write count"}, wr_n, ne);
      chk(tag, "address/data mismatches", bad, 0);
      for (int i = 0; i < 64; i++) m_val[i] = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin m_val[i] = 1'b0; m_dat[i] = '0; end
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", int'(busy), 0);
      chk("R1", "mem_we in reset", int'(mem_we), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1, R5: nothing captured after reset, so STOP does nothing
      busy_cnt = 0; wr_n = 0;
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      repeat (5) @(negedge clk);
      chk("R5", "busy after empty stop", busy_cnt, 0);
      chk("R5", "writes after empty stop", wr_n, 0);

      for (int v = 0; v < NV; v++) begin
         load(VEC[v][27:16]);
         send(int'(VEC[v][15:8]), VEC[v][7:0]);
         commit(1'b0);
         check_commit(VTAG[v]);
      end

      // R8: pokes during commit are ignored
      load(12'h040);
      send(3, 8'h55);
      commit(1'b1);
      check_commit("R8");
      busy_cnt = 0; wr_n = 0;
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8", "busy after stop following poked commit", busy_cnt, 0);

      // R9: second transfer writes only its own byte
      load(12'h300);
      send(16, 8'hA0);
      commit(1'b0);
      check_commit("R9");
      load(12'h31A);
      send(1, 8'h77);
      commit(1'b0);
      check_commit("R9");

      // R11: load beats byte; stop beats both
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = 12'h580; byte_valid = 1'b1; byte_data = 8'h99;
      m_hi = 6'h16; m_ptr = 6'h00;
      @(negedge clk);
      ld_valid = 1'b0; byte_valid = 1'b0;
      send(1, 8'h3C);
      commit(1'b0);
      check_commit("R11");
      @(negedge clk);
      stop = 1'b1; byte_valid = 1'b1; byte_data = 8'h11;
      @(negedge clk);
      stop = 1'b0; byte_valid = 1'b0;
      busy_cnt = 0; wr_n = 0;
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      repeat (5) @(negedge clk);
      chk("R11", "byte beside stop captured", busy_cnt, 0);

      chk("R10", "writes outside busy", stray, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule